// File: doc/BRIEF.md
# Segment Base Linear Address Generator

This block turns a logical address into a linear address. A logical address is a segment identifier plus an effective offset. The block holds a base, a 32-bit limit and a descriptor privilege level for each of six segment registers. Software loads these values through a simple write port. On each request the block applies the current operating mode, checks the privilege and the limit, and returns a registered result one clock later.

Three modes are supported:

- **Legacy protected mode.** Addresses are 32 bits wide and the limit is checked.
- **Long mode.** The four ordinary segments have a base of zero and no limit is checked. The two auxiliary segments keep a full 64-bit base.
- **Compatibility mode.** This is the 32-bit view used inside a 64-bit environment. Only the low half of every base takes part.

A flat setup has base 0 and limit 0xFFFF_FFFF. This is the reset state, and in it the linear address equals the low 32 bits of the offset.

The block is placed in an address generation path ahead of page translation. Descriptor fetch and selector decoding stay with the caller. The caller presents the already-loaded segment attributes through the write port.

Top module: `seg_linear_addr_gen`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, every output is 0. Reset leaves segments 0..5 with base 0, limit 0xFFFF_FFFF and privilege level 3.
- R2: A cycle with `wrEn` high and `wrSeg` in 0..5 replaces that segment's base, limit and privilege level at the clock edge. A request in the same cycle reads the values held before that edge.
- R3: In mode 0 (legacy), and in mode 3, which is treated as legacy, `outLinear` is `{32'b0, (base[31:0] + offset[31:0]) mod 2^32}`.
- R4: In mode 2 (long), segments 0..3 (code, data, extra, stack) ignore their stored base, so `outLinear` equals the full 64-bit offset.
- R5: In mode 2, segments 4 and 5 (the two auxiliary segments) produce `outLinear = (base + offset) mod 2^64` using the full 64-bit base.
- R6: In mode 1 (compatibility), every segment, including 4 and 5, uses only `base[31:0]`. The result is formed as in R3, with bits 63:32 equal to zero.
- R7: In modes 0, 1 and 3, `outLimitFault` is set with `outValid` when `offset[31:0] > limit`. An offset equal to the limit does not fault. In mode 2 the flag is never set.
- R8: A request with `reqCpl == 3` to a segment whose privilege level is 0 sets `outPrivFault` for one cycle. In that cycle `outValid`, `outLimitFault` and `outLinear` are all 0.
- R9: Each accepted request raises `outValid` for exactly the one cycle after `reqValid`. Whenever `outValid` is low, `outLinear` and `outLimitFault` are 0.
- R10: Segment identifiers 6 and 7 read as base 0, limit 0xFFFF_FFFF and privilege level 3. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load strobe for segment attributes |
| wrSeg | input | 3 | Segment to load (0 code, 1 data, 2 extra, 3 stack, 4/5 auxiliary) |
| wrBase | input | 64 | Base value to load |
| wrLimit | input | 32 | Limit value to load |
| wrDpl | input | 2 | Descriptor privilege level to load |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 2 | 0 legacy, 1 compatibility, 2 long, 3 legacy |
| reqSeg | input | 3 | Segment of the request |
| reqOffset | input | 64 | Effective offset |
| reqCpl | input | 2 | Current privilege level |
| outValid | output | 1 | One-cycle result strobe |
| outLinear | output | 64 | Linear address |
| outLimitFault | output | 1 | Offset beyond limit |
| outPrivFault | output | 1 | Privilege check failed |

## Verification
The assertions assume that `reqMode` is held stable during the cycle it is sampled. They also assume that `reqValid` is a plain per-cycle strobe and that no request is left pending.

The stimulus drives every input at the falling edge and leaves it stable through the next rising edge. Random loads and requests are interleaved freely, including loads and requests in the same cycle. All four mode codes and all eight segment identifiers are drawn.

The offsets are mixed between fully random values and values close to the current limit, so that both sides of the limit comparison are exercised.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  localparam int ADDR_W  = 64;
  localparam int NARROW_W = 32;
  localparam int NUM_SEG = 6;
  localparam int SEG_W   = 3;
  localparam int PL_W    = 2;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_LEGACY = 2'd0,
    MODE_COMPAT = 2'd1,
    MODE_LONG   = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  localparam logic [SEG_W-1:0] SEG_AUX0 = 3'd4;
  localparam logic [SEG_W-1:0] SEG_AUX1 = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;    // load the addressed segment
    logic issue;       // request accepted, produce a result
    logic privDeny;    // request rejected on privilege
    logic zeroBase;    // long mode, ordinary segment
    logic wideBase;    // long mode, auxiliary segment
    logic checkLimit;  // narrow modes compare against limit
  } ctrlStrobes_t;
endpackage

// File: rtl/segaddr_ctrl.sv
module segaddr_ctrl
  import segaddr_pkg::*;
#(
  parameter int NSEG = NUM_SEG,
  parameter int SW   = SEG_W,
  parameter int PW   = PL_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [SW-1:0]         wrSeg,
  input  logic                  reqValid,
  input  logic [MODE_W-1:0]     reqMode,
  input  logic [SW-1:0]         reqSeg,
  input  logic [PW-1:0]         reqCpl,
  input  logic [PW-1:0]         selDpl,
  output ctrlStrobes_t          ctrl
);
  localparam logic [PW-1:0] PL_USER   = '1;
  localparam logic [PW-1:0] PL_KERNEL = '0;

  logic isLong;
  logic isAux;
  logic denied;

  always_comb begin
    isLong = (reqMode == MODE_LONG);
    isAux  = (reqSeg == SEG_AUX0) || (reqSeg == SEG_AUX1);
    denied = (reqCpl == PL_USER) && (selDpl == PL_KERNEL);

    ctrl            = '0;
    ctrl.wrStrobe   = wrEn && (32'(wrSeg) < NSEG);
    ctrl.privDeny   = reqValid && denied;
    ctrl.issue      = reqValid && !denied;
    ctrl.zeroBase   = isLong && !isAux;
    ctrl.wideBase   = isLong && isAux;
    ctrl.checkLimit = !isLong;
  end

  // R8
  deny_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.privDeny |-> !ctrl.issue);

  // R4
  base_sel_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.zeroBase && ctrl.wideBase));
endmodule

// File: rtl/segaddr_dp.sv
module segaddr_dp
  import segaddr_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NW   = NARROW_W,
  parameter int NSEG = NUM_SEG,
  parameter int SW   = SEG_W,
  parameter int PW   = PL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [SW-1:0]      wrSeg,
  input  logic [AW-1:0]      wrBase,
  input  logic [NW-1:0]      wrLimit,
  input  logic [PW-1:0]      wrDpl,
  input  logic [SW-1:0]      reqSeg,
  input  logic [AW-1:0]      reqOffset,
  output logic [PW-1:0]      selDpl,
  output logic               outValid,
  output logic [AW-1:0]      outLinear,
  output logic               outLimitFault,
  output logic               outPrivFault
);
  localparam int HI_W = AW - NW;

  logic [AW-1:0] baseQ  [NSEG];
  logic [NW-1:0] limitQ [NSEG];
  logic [PW-1:0] dplQ   [NSEG];

  // per-segment attribute registers
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[s]  <= '0;
        limitQ[s] <= '1;
        dplQ[s]   <= '1;
      end else if (ctrl.wrStrobe && (wrSeg == SW'(s))) begin
        baseQ[s]  <= wrBase;
        limitQ[s] <= wrLimit;
        dplQ[s]   <= wrDpl;
      end
    end
  end

  logic [AW-1:0] selBase;
  logic [NW-1:0] selLimit;
  logic [NW-1:0] narrowSum;
  logic [AW-1:0] wideSum;
  logic [AW-1:0] linNext;
  logic          overLimit;

  always_comb begin
    selBase  = '0;
    selLimit = '1;
    selDpl   = '1;
    for (int s = 0; s < NSEG; s++) begin
      if (reqSeg == SW'(s)) begin
        selBase  = baseQ[s];
        selLimit = limitQ[s];
        selDpl   = dplQ[s];
      end
    end
  end

  always_comb begin
    narrowSum = selBase[NW-1:0] + reqOffset[NW-1:0];
    wideSum   = selBase + reqOffset;
    overLimit = reqOffset[NW-1:0] > selLimit;
    if (ctrl.zeroBase)      linNext = reqOffset;
    else if (ctrl.wideBase) linNext = wideSum;
    else                    linNext = {{HI_W{1'b0}}, narrowSum};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outLinear     <= '0;
      outLimitFault <= 1'b0;
      outPrivFault  <= 1'b0;
    end else begin
      outValid      <= ctrl.issue;
      outLinear     <= ctrl.issue ? linNext : '0;
      outLimitFault <= ctrl.issue && ctrl.checkLimit && overLimit;
      outPrivFault  <= ctrl.privDeny;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outLinear == '0) && !outLimitFault);

  // R2
  seg_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.wrStrobe) |-> $stable(baseQ[0]) && $stable(limitQ[0]));
endmodule

// File: rtl/seg_linear_addr_gen.sv
module seg_linear_addr_gen
  import segaddr_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NW   = NARROW_W,
  parameter int NSEG = NUM_SEG,
  parameter int SW   = SEG_W,
  parameter int PW   = PL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SW-1:0]      wrSeg,
  input  logic [AW-1:0]      wrBase,
  input  logic [NW-1:0]      wrLimit,
  input  logic [PW-1:0]      wrDpl,
  input  logic               reqValid,
  input  logic [MODE_W-1:0]  reqMode,
  input  logic [SW-1:0]      reqSeg,
  input  logic [AW-1:0]      reqOffset,
  input  logic [PW-1:0]      reqCpl,
  output logic               outValid,
  output logic [AW-1:0]      outLinear,
  output logic               outLimitFault,
  output logic               outPrivFault
);
  ctrlStrobes_t   ctrl;
  logic [PW-1:0]  selDpl;

  segaddr_ctrl #(.NSEG(NSEG), .SW(SW), .PW(PW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSeg    (wrSeg),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqSeg   (reqSeg),
    .reqCpl   (reqCpl),
    .selDpl   (selDpl),
    .ctrl     (ctrl)
  );

  segaddr_dp #(.AW(AW), .NW(NW), .NSEG(NSEG), .SW(SW), .PW(PW)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .wrSeg         (wrSeg),
    .wrBase        (wrBase),
    .wrLimit       (wrLimit),
    .wrDpl         (wrDpl),
    .reqSeg        (reqSeg),
    .reqOffset     (reqOffset),
    .selDpl        (selDpl),
    .outValid      (outValid),
    .outLinear     (outLinear),
    .outLimitFault (outLimitFault),
    .outPrivFault  (outPrivFault)
  );

  // R9
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || outPrivFault) |-> $past(reqValid));

  // R8
  priv_blocks_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPrivFault |-> !outValid && !outLimitFault && (outLinear == '0));

  // R7
  long_no_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(reqMode) == MODE_LONG)) |-> !outLimitFault);

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(reqMode) != MODE_LONG)) |-> (outLinear[AW-1:NW] == '0));
endmodule

// File: tb/sim_seg_linear_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_linear_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSeg = '0;
  logic [63:0] wrBase = '0;
  logic [31:0] wrLimit = '0;
  logic [1:0]  wrDpl = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = '0;
  logic [2:0]  reqSeg = '0;
  logic [63:0] reqOffset = '0;
  logic [1:0]  reqCpl = '0;
  logic        outValid;
  logic [63:0] outLinear;
  logic        outLimitFault;
  logic        outPrivFault;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  logic [63:0] mBase  [8];
  logic [31:0] mLimit [8];
  logic [1:0]  mDpl   [8];

  always #5 clk = ~clk;

  seg_linear_addr_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSeg(wrSeg), .wrBase(wrBase),
    .wrLimit(wrLimit), .wrDpl(wrDpl), .reqValid(reqValid), .reqMode(reqMode),
    .reqSeg(reqSeg), .reqOffset(reqOffset), .reqCpl(reqCpl),
    .outValid(outValid), .outLinear(outLinear),
    .outLimitFault(outLimitFault), .outPrivFault(outPrivFault)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  function automatic void modelReset();
    for (int s = 0; s < 8; s++) begin
      mBase[s] = '0; mLimit[s] = '1; mDpl[s] = 2'd3;
    end
  endfunction

  function automatic logic [63:0] expLin(logic [1:0] md, logic [2:0] sg, logic [63:0] off);
    logic [31:0] n;
    if (md == 2'd2) begin
      if (sg == 3'd4 || sg == 3'd5) return mBase[sg] + off;
      return off;
    end
    n = mBase[sg][31:0] + off[31:0];
    return {32'b0, n};
  endfunction

  // one cycle: drive at negedge, check at following negedge
  task automatic step(string tag, bit we, logic [2:0] ws, logic [63:0] wb,
                      logic [31:0] wl, logic [1:0] wd, bit rv, logic [1:0] md,
                      logic [2:0] sg, logic [63:0] off, logic [1:0] cpl);
    bit eDeny, eValid, eLim;
    logic [63:0] eLin;
    wrEn = we; wrSeg = ws; wrBase = wb; wrLimit = wl; wrDpl = wd;
    reqValid = rv; reqMode = md; reqSeg = sg; reqOffset = off; reqCpl = cpl;
    eDeny  = rv && (cpl == 2'd3) && (mDpl[sg] == 2'd0);
    eValid = rv && !eDeny;
    eLin   = eValid ? expLin(md, sg, off) : 64'd0;
    eLim   = eValid && (md != 2'd2) && (off[31:0] > mLimit[sg]);
    @(posedge clk);
    if (we && ws < 3'd6) begin
      mBase[ws] = wb; mLimit[ws] = wl; mDpl[ws] = wd;
    end
    @(negedge clk);
    check({tag, " valid"},  {63'd0, outValid},      {63'd0, eValid});
    check({tag, " linear"}, outLinear,              eLin);
    check({tag, " limit"},  {63'd0, outLimitFault}, {63'd0, eLim});
    check({tag, " priv"},   {63'd0, outPrivFault},  {63'd0, eDeny});
    wrEn = 0; reqValid = 0;
  endtask

  task automatic load(logic [2:0] s, logic [63:0] b, logic [31:0] l, logic [1:0] d);
    step("R2 load", 1, s, b, l, d, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, outValid}, 64'd0);
    check("R1 reset linear", outLinear, 64'd0);
    check("R1 reset faults", {62'd0, outLimitFault, outPrivFault}, 64'd0);
    rstN = 1;
    @(negedge clk);
    check("R1 post-reset idle", {62'd0, outValid, outPrivFault}, 64'd0);

    // R1 flat legacy: linear equals low offset
    step("R1 flat legacy", 0, 0, 0, 0, 0, 1, 2'd0, 3'd1, 64'hDEAD_BEEF_1234_5678, 2'd3);
    // R9 idle cycle
    step("R9 idle", 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 64'h55, 2'd0);

    load(3'd0, 64'hFFFF_0000_0001_0000, 32'h0000_FFFF, 2'd1);
    load(3'd4, 64'hAAAA_BBBB_F000_0000, 32'h2000_0000, 2'd1);
    // R3 legacy wrap of 32-bit sum
    step("R3 legacy CS", 0, 0, 0, 0, 0, 1, 2'd0, 3'd0, 64'h0000_0000_0000_1234, 2'd0);
    step("R3 mode3 as legacy", 0, 0, 0, 0, 0, 1, 2'd3, 3'd4, 64'h0000_0000_1000_0000, 2'd0);
    // R4 long ordinary segment ignores base
    step("R4 long CS", 0, 0, 0, 0, 0, 1, 2'd2, 3'd0, 64'h1234_5678_9ABC_DEF0, 2'd0);
    // R5 long aux full base
    step("R5 long aux", 0, 0, 0, 0, 0, 1, 2'd2, 3'd4, 64'h0000_0001_2000_0000, 2'd0);
    // R6 compat aux low base only
    step("R6 compat aux", 0, 0, 0, 0, 0, 1, 2'd1, 3'd4, 64'h0000_0000_1800_0000, 2'd0);
    // R7 limit boundary
    step("R7 at limit", 0, 0, 0, 0, 0, 1, 2'd0, 3'd0, 64'h0000_FFFF, 2'd0);
    step("R7 over limit", 0, 0, 0, 0, 0, 1, 2'd1, 3'd0, 64'h0001_0000, 2'd0);
    step("R7 long no limit", 0, 0, 0, 0, 0, 1, 2'd2, 3'd0, 64'h0001_0000, 2'd0);
    // R8 privilege
    load(3'd1, 64'h100, 32'hFFFF_FFFF, 2'd0);
    step("R8 user to kernel", 0, 0, 0, 0, 0, 1, 2'd0, 3'd1, 64'h20, 2'd3);
    step("R8 kernel to kernel", 0, 0, 0, 0, 0, 1, 2'd0, 3'd1, 64'h20, 2'd0);
    // R10 unused ids
    step("R10 write seg6", 1, 3'd6, 64'h7777, 32'h10, 2'd0, 0, 0, 0, 0, 0);
    step("R10 read seg6", 0, 0, 0, 0, 0, 1, 2'd0, 3'd6, 64'hFFFF_FFF0, 2'd3);
    step("R10 read seg7 long", 0, 0, 0, 0, 0, 1, 2'd2, 3'd7, 64'hABCD, 2'd3);
    // R2 same-cycle write and read sees old value
    step("R2 same cycle", 1, 3'd2, 64'h9000, 32'h10, 2'd2, 1, 2'd0, 3'd2, 64'h40, 2'd0);
    step("R2 after write", 0, 0, 0, 0, 0, 1, 2'd0, 3'd2, 64'h40, 2'd0);

    // R9 random mix
    for (int i = 0; i < 3000; i++) begin
      bit we, rv;
      logic [2:0] ws, sg;
      logic [63:0] wb, off;
      logic [31:0] wl;
      logic [1:0] wd, md, cpl;
      we  = ($urandom % 4) == 0;
      ws  = 3'($urandom % 8);
      wb  = {$urandom, $urandom};
      wl  = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : $urandom;
      wd  = 2'($urandom % 4);
      rv  = ($urandom % 5) != 0;
      md  = 2'($urandom % 4);
      sg  = 3'($urandom % 8);
      cpl = 2'($urandom % 4);
      off = {$urandom, $urandom};
      if ($urandom % 2 == 0)
        off[31:0] = mLimit[sg] + 32'($urandom % 3) - 32'd1;
      step("R9 random", we, ws, wb, wl, wd, rv, md, sg, off, cpl);
    end

    finishRun();
  end
endmodule